// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This unit decides which of a serial port's five interrupt causes is presented to the processor, and when that cause is acknowledged. The receiver, transmitter and modem-line logic each send a one-cycle event strobe. The unit keeps one sticky pending bit per cause. A cause is latched even while its enable bit is clear, so turning the enable on later exposes it at once.

Each cycle the unit picks the highest-priority cause that is both pending and enabled. It registers that cause's identification code and drives a single active-high interrupt request from it. A small register bus writes and reads the enable register and reads the identification register. It also carries the accesses whose side effects acknowledge causes: a receive-buffer read, a transmit-holding write, and reads of the line-status and modem-status registers. The contents of those registers belong to neighbouring blocks, and this unit returns zero for them.

Top module: `uart_irq_prio`

## Requirements
- R1: While reset is high and after it is released, the identification code is 0x01, the interrupt request is low, the enable register reads 0, and no cause is pending.
- R2: An event strobe (`ev_set` bit 0 line status, 1 receive data, 2 character timeout, 3 holding empty, 4 modem status) latches that cause as pending, whatever the enable bits are. It stays pending until its acknowledging access.
- R3: Among pending, enabled causes the code shows the highest in the order line status (0x06), receive data (0x04), character timeout (0x0C), holding empty (0x02), modem status (0x00). With none, the code is 0x01.
- R4: Enable register bits: bit 0 gates both receive data and character timeout, bit 1 gates holding empty, bit 2 gates line status, bit 3 gates modem status. The timeout cause has no enable bit of its own.
- R5: A write to address 1 sets the enable register from data bits 3:0. The code reflects the new enables on the cycle after the write. A read of address 1 returns the enables in bits 3:0 and zeros above.
- R6: A read of address 2 returns {2'b11, 2'b00, code}. The interrupt request is high exactly when code bit 0 is low.
- R7: A read of address 2 acknowledges holding empty only when the code being returned is 0x02. Otherwise holding empty stays pending.
- R8: A write to address 0 (transmit holding) acknowledges holding empty.
- R9: A read of address 5 (line status) acknowledges line status.
- R10: A read of address 6 (modem status) acknowledges modem status.
- R11: A read of address 0 (receive buffer) acknowledges both receive data and character timeout.
- R12: An event strobe arriving in the same cycle as the access that acknowledges that cause wins: the cause stays pending.
- R13: Code and request are registered. After an acknowledgement, the next enabled pending cause is shown on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_set | input | 5 | One-cycle cause strobes, bit order as in R2 |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for enable and identification registers, zero otherwise |
| irq | output | 1 | Interrupt request |
| ident | output | 4 | Current identification code |

## Verification
Two things can land on one clock edge: a cause's event strobe and the register access that acknowledges that same cause. The bench provokes this by raising the receive-data strobe while reading the receive buffer, and expects the cause to survive and still be reported on the next cycle. A second collision is an identification read made while a higher cause hides a pending holding-empty cause. Here the read must leave that cause intact, and it must appear once the higher cause is cleared.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC  = 5;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;
    localparam int ENABLE_W = 4;
    localparam int CODE_W   = 4;

    // source index doubles as priority rank (0 highest)
    localparam int SRC_LINE    = 0;
    localparam int SRC_RXDATA  = 1;
    localparam int SRC_TIMEOUT = 2;
    localparam int SRC_TXEMPTY = 3;
    localparam int SRC_MODEM   = 4;

    localparam logic [CODE_W-1:0] CODE_NONE    = 4'h1;
    localparam logic [CODE_W-1:0] CODE_MODEM   = 4'h0;
    localparam logic [CODE_W-1:0] CODE_TXEMPTY = 4'h2;
    localparam logic [CODE_W-1:0] CODE_RXDATA  = 4'h4;
    localparam logic [CODE_W-1:0] CODE_LINE    = 4'h6;
    localparam logic [CODE_W-1:0] CODE_TIMEOUT = 4'hC;

    localparam logic [ADDR_W-1:0] ADDR_DATA   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_IDENT  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_LINE   = 3'd5;
    localparam logic [ADDR_W-1:0] ADDR_MODEM  = 3'd6;

    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef struct packed {
        logic rd_data;
        logic wr_data;
        logic wr_enable;
        logic rd_enable;
        logic rd_ident;
        logic rd_line;
        logic rd_modem;
    } bus_evt_t;

    function automatic logic [CODE_W-1:0] code_of(input int idx);
        case (idx)
            SRC_LINE:    return CODE_LINE;
            SRC_RXDATA:  return CODE_RXDATA;
            SRC_TIMEOUT: return CODE_TIMEOUT;
            SRC_TXEMPTY: return CODE_TXEMPTY;
            default:     return CODE_MODEM;
        endcase
    endfunction

    function automatic logic [NUM_SRC-1:0] expand_enable(input logic [ENABLE_W-1:0] en);
        logic [NUM_SRC-1:0] m;
        m[SRC_LINE]    = en[EN_LINE];
        m[SRC_RXDATA]  = en[EN_RX];
        m[SRC_TIMEOUT] = en[EN_RX];
        m[SRC_TXEMPTY] = en[EN_TX];
        m[SRC_MODEM]   = en[EN_MODEM];
        return m;
    endfunction

endpackage

// File: rtl/uart_irq_pending.sv
module uart_irq_pending
    import uart_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_d,
    output logic [N-1:0] pend_q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            if (set_i[i])      pend_d[i] = 1'b1;
            else if (clr_i[i]) pend_d[i] = 1'b0;
            else               pend_d[i] = pend_q[i];
        end

        always_ff @(posedge clk) begin
            if (rst) pend_q[i] <= 1'b0;
            else     pend_q[i] <= pend_d[i];
        end
    end

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [CODE_W-1:0]  code_o
);

    logic [NUM_SRC-1:0] live;
    assign live = pend_i & mask_i;

    always_comb begin
        code_o = CODE_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (live[i]) code_o = code_of(i);
        end
    end

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [CODE_W-1:0]   code_q,
    output logic [ENABLE_W-1:0] ier_d,
    output logic [ENABLE_W-1:0] ier_q,
    output logic [NUM_SRC-1:0]  clr_o,
    output logic [DATA_W-1:0]   rdata_o
);

    bus_evt_t ev;
    logic     unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:ENABLE_W];

    always_comb begin
        ev.rd_data   = bus_rd && (bus_addr == ADDR_DATA);
        ev.wr_data   = bus_wr && (bus_addr == ADDR_DATA);
        ev.wr_enable = bus_wr && (bus_addr == ADDR_ENABLE);
        ev.rd_enable = bus_rd && (bus_addr == ADDR_ENABLE);
        ev.rd_ident  = bus_rd && (bus_addr == ADDR_IDENT);
        ev.rd_line   = bus_rd && (bus_addr == ADDR_LINE);
        ev.rd_modem  = bus_rd && (bus_addr == ADDR_MODEM);
    end

    always_comb begin
        clr_o              = '0;
        clr_o[SRC_LINE]    = ev.rd_line;
        clr_o[SRC_RXDATA]  = ev.rd_data;
        clr_o[SRC_TIMEOUT] = ev.rd_data;
        clr_o[SRC_TXEMPTY] = ev.wr_data || (ev.rd_ident && (code_q == CODE_TXEMPTY));
        clr_o[SRC_MODEM]   = ev.rd_modem;
    end

    assign ier_d = ev.wr_enable ? bus_wdata[ENABLE_W-1:0] : ier_q;

    always_ff @(posedge clk) begin
        if (rst) ier_q <= '0;
        else     ier_q <= ier_d;
    end

    always_comb begin
        rdata_o = '0;
        if (ev.rd_ident)
            rdata_o = {2'b11, {(DATA_W-2-CODE_W){1'b0}}, code_q};
        else if (ev.rd_enable)
            rdata_o = {{(DATA_W-ENABLE_W){1'b0}}, ier_q};
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  ev_set,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq,
    output logic [CODE_W-1:0]   ident
);

    logic [NUM_SRC-1:0]  pend_d, pend_q, clr;
    logic [ENABLE_W-1:0] ier_d, ier_q;
    logic [CODE_W-1:0]   code_d, code_q;

    uart_irq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .code_q    (code_q),
        .ier_d     (ier_d),
        .ier_q     (ier_q),
        .clr_o     (clr),
        .rdata_o   (bus_rdata)
    );

    uart_irq_pending #(.N(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .set_i  (ev_set),
        .clr_i  (clr),
        .pend_d (pend_d),
        .pend_q (pend_q)
    );

    uart_irq_arbiter u_arb (
        .pend_i (pend_d),
        .mask_i (expand_enable(ier_d)),
        .code_o (code_d)
    );

    always_ff @(posedge clk) begin
        if (rst) code_q <= CODE_NONE;
        else     code_q <= code_d;
    end

    assign ident = code_q;
    assign irq   = ~code_q[0];

endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk
    import uart_irq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [NUM_SRC-1:0]  ev_set,
    input logic                bus_rd,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_SRC-1:0]  pend,
    input logic [ENABLE_W-1:0] ier,
    input logic [CODE_W-1:0]   code,
    input logic                irq
);

    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (code == CODE_NONE && pend == '0));

    a_r6_irq_needs_pending: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pend != '0));

    a_r3_line_wins: assert property (@(posedge clk) disable iff (rst)
        (pend[SRC_LINE] && ier[EN_LINE]) |-> (code == CODE_LINE));

    a_r2_strobe_latches: assert property (@(posedge clk) disable iff (rst)
        ev_set[SRC_RXDATA] |=> pend[SRC_RXDATA]);

    a_r8_thr_write_acks: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_DATA && !ev_set[SRC_TXEMPTY]) |=> !pend[SRC_TXEMPTY]);

    a_r9_lsr_read_acks: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_LINE && !ev_set[SRC_LINE]) |=> !pend[SRC_LINE]);

    a_r7_ident_keeps_hidden_tx: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_IDENT && code != CODE_TXEMPTY && pend[SRC_TXEMPTY])
        |=> pend[SRC_TXEMPTY]);

endmodule

bind uart_irq_prio uart_irq_prio_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ev_set   (ev_set),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .pend     (pend_q),
    .ier      (ier_q),
    .code     (code_q),
    .irq      (irq)
);

// File: tb/tb_uart_irq_prio.sv
module tb_uart_irq_prio;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] ev_set = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic [3:0] ident;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic [4:0] mp = '0;
    logic [3:0] mier = '0;

    typedef struct { logic [3:0] code; string tag; } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_prio dut (
        .clk(clk), .rst(rst), .ev_set(ev_set), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .ident(ident)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // R3/R4 priority from the requirement text
    function automatic logic [3:0] exp_code(input logic [4:0] p, input logic [3:0] e);
        logic [4:0] m;
        m = p & {e[3], e[1], e[0], e[0], e[2]};
        if (m[0]) return 4'h6;
        if (m[1]) return 4'h4;
        if (m[2]) return 4'hC;
        if (m[3]) return 4'h2;
        if (m[4]) return 4'h0;
        return 4'h1;
    endfunction

    task automatic step(input logic [4:0] s, input bit rd, input bit wr,
                        input logic [2:0] a, input logic [7:0] wd, input string tag);
        logic [3:0] cur;
        logic [7:0] er;
        logic [4:0] clr;
        @(negedge clk);
        ev_set = s; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        cur = exp_code(mp, mier);
        er = 8'h00;
        if (rd && a == 3'd2) er = {4'hC, cur};
        else if (rd && a == 3'd1) er = {4'h0, mier};
        #1;
        check(bus_rdata == er, {tag, " rdata"}, bus_rdata, er);
        clr = '0;
        if (rd && a == 3'd5) clr[0] = 1'b1;
        if (rd && a == 3'd0) clr[2:1] = 2'b11;
        if ((wr && a == 3'd0) || (rd && a == 3'd2 && cur == 4'h2)) clr[3] = 1'b1;
        if (rd && a == 3'd6) clr[4] = 1'b1;
        mp = (mp & ~clr) | s;
        if (wr && a == 3'd1) mier = wd[3:0];
        q.push_back('{exp_code(mp, mier), tag});
        @(posedge clk);
        @(negedge clk);
        ev_set = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    // monitor: pops expected results after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(ident == e.code, {e.tag, " code"}, ident, e.code);
                check(irq == ~e.code[0], {e.tag, " irq R6"}, irq, ~e.code[0]);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(ident == 4'h1 && irq == 1'b0, "R1 in reset", ident, 1);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check(ident == 4'h1 && irq == 1'b0, "R1 after reset", ident, 1);

        step(5'b00000, 1, 0, 3'd1, 0, "R1 enable reads zero");
        step(5'b01000, 0, 0, 0, 0, "R2 latched while disabled");
        step(5'b00000, 0, 1, 3'd1, 8'hFF, "R5 enable exposes pending");
        step(5'b00000, 1, 0, 3'd1, 0, "R5 enable readback upper zero");
        step(5'b10000, 0, 0, 0, 0, "R3 modem below holding empty");
        step(5'b00001, 0, 0, 0, 0, "R3 line status on top");
        step(5'b00000, 1, 0, 3'd2, 0, "R7 ident read keeps hidden tx");
        step(5'b00000, 1, 0, 3'd5, 0, "R9 line read acks, R13 next shown");
        step(5'b00000, 1, 0, 3'd2, 0, "R7 ident read acks reported tx R6");
        step(5'b00000, 1, 0, 3'd6, 0, "R10 modem read acks");
        step(5'b00000, 0, 1, 3'd1, 8'h0E, "R4 rx enable off");
        step(5'b00100, 0, 0, 0, 0, "R4 timeout gated by rx bit");
        step(5'b00000, 0, 1, 3'd1, 8'h0F, "R4 timeout shows with rx bit");
        step(5'b00010, 0, 0, 0, 0, "R3 rx data over timeout");
        step(5'b00000, 1, 0, 3'd0, 0, "R11 buffer read acks both");
        step(5'b01000, 0, 0, 0, 0, "R2 holding empty raised");
        step(5'b00000, 0, 1, 3'd0, 8'h55, "R8 holding write acks");
        step(5'b00010, 1, 0, 3'd0, 0, "R12 strobe beats buffer read");
        step(5'b00000, 1, 0, 3'd0, 0, "R11 second buffer read");
        step(5'b11111, 0, 0, 0, 0, "R3 all pending");
        step(5'b00000, 0, 1, 3'd1, 8'h02, "R5 only tx enabled");
        step(5'b01000, 0, 1, 3'd0, 0, "R12 tx strobe beats holding write");
        step(5'b00000, 0, 1, 3'd0, 0, "R8 holding write acks again");
        step(5'b00000, 0, 1, 3'd1, 8'h0F, "R13 line shown after re-enable");
        step(5'b00000, 1, 0, 3'd5, 0, "R9 line read, rx next");
        step(5'b00000, 1, 0, 3'd0, 0, "R11 buffer read, modem next");
        step(5'b00000, 1, 0, 3'd6, 0, "R10 modem read, idle");
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog expired actual=0 expected=1");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule